// File: doc/BRIEF.md
# Multiphase Clock Distributor with Phase Shedding

This block sits between the master clock generator of a ripple-regulated multiphase buck controller and its per-phase pulse-width channels. Each single-cycle master pulse is handed to exactly one phase. The phase that receives it gets a one-cycle phase clock, and that phase's PWM latch is set. The latch clears when the phase's turn-off comparator input is seen high. The comparators, ripple capacitors and error amplifier are analog and lie outside the block; here they appear only as synchronous digital inputs.

The rotation covers the enabled phases in index order. Phase 1 always runs. Two board straps can remove phase 2 or phase 3 for good. At run time, the active-low light-load input sheds phase 3 and the deep-sleep input sheds phase 2. The phase mask is resampled only when a master pulse arrives, so the rotation length never changes between pulses.

A compensation-switch output is on while exactly two phases are applied. When the rotation pointer lands on a phase that has just been shed, that pulse goes to phase 1 and the rotation restarts from there.

Top module: `mphase_clk_dist`

## Requirements
- R1: While reset is high and in the first cycle after it, every phase clock, every PWM output and the compensation switch are low.
- R2: With all three phases enabled, successive master pulses reach phases 1, 2, 3, 1, … The phase clock goes high for one cycle, in the cycle after the edge at which the pulse is sampled.
- R3: With light-load asserted (lowload_n low) and phase 2 enabled, the pulses alternate between phases 1 and 2.
- R4: With both phase 2 and phase 3 removed, every pulse reaches phase 1.
- R5: A phase's PWM output rises in the same cycle as its phase clock. It stays high until its turn-off comparator bit is sampled high, and falls one cycle later.
- R6: If the turn-off comparator is already high when the clock arrives, the PWM output is high for exactly one cycle.
- R7: A shed phase receives no clock. If its PWM output is high when the shedding is applied, it is forced low at that master pulse.
- R8: strap_off bit 1 removes phase 2 and bit 2 removes phase 3 whatever the run-time inputs are. Bit 0 has no effect.
- R9: A change of lowload_n or deep_sleep has no visible effect until the next master pulse.
- R10: If the phase the pointer designates is disabled in the mask sampled at a pulse, that pulse goes to phase 1. The rotation then continues from phase 1.
- R11: fb_sw is high exactly when the mask applied at the last pulse holds two phases. With one or three phases it is low.
- R12: At most one phase clock is high in any cycle. A phase clock appears only in the cycle after a master pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_pulse | input | 1 | Master clock one-shot, one cycle per pulse |
| lowload_n | input | 1 | Active-low light-load flag; low sheds phase 3 |
| deep_sleep | input | 1 | Deep-sleep flag; high sheds phase 2 |
| strap_off | input | NUM_PH | Static phase-removal straps; bit 0 has no effect |
| ph_off_cmp | input | NUM_PH | Per-phase ripple-versus-window turn-off comparator |
| ph_clk | output | NUM_PH | Per-phase one-cycle clock |
| ph_pwm | output | NUM_PH | Per-phase PWM output |
| fb_sw | output | 1 | Compensation switch, on with two applied phases |

## Verification
The hardest case to reach is the pointer restart. The pointer must be parked on phase 3 (or phase 2), and that phase must then be shed between two pulses. The next pulse should go to phase 1 and not to the following enabled phase. A plain port view reaches this state only through an exact count of earlier pulses. The vector table therefore lays out its pulses so the pointer sits on the phase that the next row sheds, for both the light-load and the strap path. Directed tests then hold a PWM output high across a shed, to show that the forced clear waits for the next pulse.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_MULTI  = 2'd2
  } ph_mode_e;

  function automatic ph_mode_e mode_of_count(input int unsigned n);
    if (n <= 1)      return MODE_SINGLE;
    else if (n == 2) return MODE_DUAL;
    else             return MODE_MULTI;
  endfunction

endpackage

// File: rtl/mpd_mask_gen.sv
module mpd_mask_gen #(
  parameter int NUM_PH      = 3,
  parameter int SLEEP_IDX   = 1,
  parameter int LOWLOAD_IDX = 2
) (
  input  logic              lowload_n,
  input  logic              deep_sleep,
  input  logic [NUM_PH-1:0] strap_off,
  output logic [NUM_PH-1:0] live_mask
);

  for (genvar g = 0; g < NUM_PH; g++) begin : g_bit
    if (g == 0) begin : g_base
      // the first phase can never be removed
      assign live_mask[g] = 1'b1;
    end else begin : g_shed
      localparam bit SHED_SLEEP = (g == SLEEP_IDX);
      localparam bit SHED_LIGHT = (g == LOWLOAD_IDX);
      logic dyn_off;
      assign dyn_off = (SHED_SLEEP && deep_sleep) || (SHED_LIGHT && !lowload_n);
      assign live_mask[g] = !strap_off[g] && !dyn_off;
    end
  end

endmodule

// File: rtl/mpd_rotator.sv
module mpd_rotator
  import mpd_pkg::*;
#(
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse,
  input  logic [NUM_PH-1:0] live_mask,
  output logic [NUM_PH-1:0] fire_nxt,
  output logic [NUM_PH-1:0] en_nxt,
  output logic [NUM_PH-1:0] clk_q,
  output ph_mode_e          mode_q
);

  localparam int PW = (NUM_PH > 1) ? $clog2(NUM_PH) : 1;

  logic [PW-1:0]     ptr_q;
  logic [PW-1:0]     tgt;
  logic [PW-1:0]     ptr_nxt;
  logic [NUM_PH-1:0] act_q;
  logic              found;
  int unsigned       idx;

  always_comb begin
    tgt = ptr_q;
    if (!live_mask[ptr_q]) tgt = '0;
    fire_nxt = '0;
    if (pulse) fire_nxt[tgt] = 1'b1;
    ptr_nxt = '0;
    found   = 1'b0;
    idx     = 0;
    for (int k = 1; k <= NUM_PH; k++) begin
      idx = (int'(tgt) + k) % NUM_PH;
      if (!found && live_mask[idx]) begin
        ptr_nxt = PW'(idx);
        found   = 1'b1;
      end
    end
    en_nxt = pulse ? live_mask : act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      act_q  <= {{(NUM_PH-1){1'b0}}, 1'b1};
      clk_q  <= '0;
      mode_q <= MODE_SINGLE;
    end else begin
      clk_q <= fire_nxt;
      if (pulse) begin
        ptr_q  <= ptr_nxt;
        act_q  <= live_mask;
        mode_q <= mode_of_count($countones(live_mask));
      end
    end
  end

endmodule

// File: rtl/mpd_pwm_latch.sv
module mpd_pwm_latch (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic set,
  input  logic off_cmp,
  output logic pwm_q
);

  always_ff @(posedge clk) begin
    if (rst)          pwm_q <= 1'b0;
    else if (!en)     pwm_q <= 1'b0;
    else if (set)     pwm_q <= 1'b1;
    else if (off_cmp) pwm_q <= 1'b0;
  end

endmodule

// File: rtl/mphase_clk_dist.sv
module mphase_clk_dist
  import mpd_pkg::*;
#(
  parameter int NUM_PH      = 3,
  parameter int SLEEP_IDX   = 1,
  parameter int LOWLOAD_IDX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclk_pulse,
  input  logic              lowload_n,
  input  logic              deep_sleep,
  input  logic [NUM_PH-1:0] strap_off,
  input  logic [NUM_PH-1:0] ph_off_cmp,
  output logic [NUM_PH-1:0] ph_clk,
  output logic [NUM_PH-1:0] ph_pwm,
  output logic              fb_sw
);

  logic [NUM_PH-1:0] live_mask;
  logic [NUM_PH-1:0] fire_nxt;
  logic [NUM_PH-1:0] en_nxt;
  ph_mode_e          mode_q;

  mpd_mask_gen #(
    .NUM_PH(NUM_PH), .SLEEP_IDX(SLEEP_IDX), .LOWLOAD_IDX(LOWLOAD_IDX)
  ) i_mask (
    .lowload_n (lowload_n),
    .deep_sleep(deep_sleep),
    .strap_off (strap_off),
    .live_mask (live_mask)
  );

  mpd_rotator #(.NUM_PH(NUM_PH)) i_rot (
    .clk      (clk),
    .rst      (rst),
    .pulse    (mclk_pulse),
    .live_mask(live_mask),
    .fire_nxt (fire_nxt),
    .en_nxt   (en_nxt),
    .clk_q    (ph_clk),
    .mode_q   (mode_q)
  );

  for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
    mpd_pwm_latch i_latch (
      .clk    (clk),
      .rst    (rst),
      .en     (en_nxt[g]),
      .set    (fire_nxt[g]),
      .off_cmp(ph_off_cmp[g]),
      .pwm_q  (ph_pwm[g])
    );
  end

  assign fb_sw = (mode_q == MODE_DUAL);

endmodule

// File: rtl/mpd_checker.sv
module mpd_checker #(
  parameter int NUM_PH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mclk_pulse,
  input logic [NUM_PH-1:0] strap_off,
  input logic [NUM_PH-1:0] ph_off_cmp,
  input logic [NUM_PH-1:0] ph_clk,
  input logic [NUM_PH-1:0] ph_pwm,
  input logic              fb_sw
);

  a_r12_clk_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ph_clk));

  a_r12_clk_after_pulse: assert property (@(posedge clk) disable iff (rst)
    (ph_clk != '0) |-> $past(mclk_pulse));

  a_r2_pulse_served: assert property (@(posedge clk) disable iff (rst)
    mclk_pulse |=> ($countones(ph_clk) == 1));

  a_r9_fbsw_at_pulse: assert property (@(posedge clk) disable iff (rst)
    !$stable(fb_sw) |-> $past(mclk_pulse));

  for (genvar g = 0; g < NUM_PH; g++) begin : g_chk
    a_r5_rise_with_clk: assert property (@(posedge clk) disable iff (rst)
      $rose(ph_pwm[g]) |-> ph_clk[g]);

    a_r6_clear_on_cmp: assert property (@(posedge clk) disable iff (rst)
      (ph_pwm[g] && ph_off_cmp[g] && !mclk_pulse) |=> !ph_pwm[g]);

    a_r7_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(ph_pwm[g]) |-> ($past(ph_off_cmp[g]) || $past(mclk_pulse)));

    if (g > 0) begin : g_strap
      a_r8_strap_blocks: assert property (@(posedge clk) disable iff (rst)
        ph_clk[g] |-> !$past(strap_off[g]));
    end
  end

endmodule

bind mphase_clk_dist mpd_checker #(.NUM_PH(NUM_PH)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .mclk_pulse(mclk_pulse),
  .strap_off (strap_off),
  .ph_off_cmp(ph_off_cmp),
  .ph_clk    (ph_clk),
  .ph_pwm    (ph_pwm),
  .fb_sw     (fb_sw)
);

// File: tb/test_mphase_clk_dist.sv
module test_mphase_clk_dist;

  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          mclk_pulse;
  logic          lowload_n;
  logic          deep_sleep;
  logic [NP-1:0] strap_off;
  logic [NP-1:0] ph_off_cmp;
  logic [NP-1:0] ph_clk;
  logic [NP-1:0] ph_pwm;
  logic          fb_sw;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mphase_clk_dist #(.NUM_PH(NP)) i_mphase_clk_dist (
    .clk(clk), .rst(rst), .mclk_pulse(mclk_pulse), .lowload_n(lowload_n),
    .deep_sleep(deep_sleep), .strap_off(strap_off), .ph_off_cmp(ph_off_cmp),
    .ph_clk(ph_clk), .ph_pwm(ph_pwm), .fb_sw(fb_sw)
  );

  // {lowload_n, deep_sleep, strap_off[2:0], expected ph_clk[2:0], expected fb_sw}
  localparam logic [8:0] VEC [19] = '{
    9'b1_0_000_001_0, 9'b1_0_000_010_0, 9'b1_0_000_100_0, 9'b1_0_000_001_0,
    9'b0_0_000_010_1, 9'b0_0_000_001_1, 9'b0_0_000_010_1, 9'b1_0_000_001_0,
    9'b1_0_000_010_0, 9'b0_0_000_001_1, 9'b0_1_000_001_0, 9'b0_1_000_001_0,
    9'b1_1_000_001_1, 9'b1_1_000_100_1, 9'b1_0_000_001_0, 9'b1_0_010_001_1,
    9'b1_0_010_100_1, 9'b1_0_110_001_0, 9'b1_0_110_001_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mclk_pulse = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // pulse sampled at one posedge; returns at the following negedge
  task automatic fire();
    @(negedge clk); mclk_pulse = 1'b1;
    @(negedge clk); mclk_pulse = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mclk_pulse = 1'b0; lowload_n = 1'b1; deep_sleep = 1'b0;
    strap_off = '0; ph_off_cmp = '1;
    repeat (3) @(negedge clk);
    chk("R1 clk in reset", 32'(ph_clk), 0);
    chk("R1 pwm in reset", 32'(ph_pwm), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 clk after reset", 32'(ph_clk), 0);
    chk("R1 fb_sw after reset", 32'(fb_sw), 0);

    // rotation table: R2 R3 R4 R8 R10 R11, comparators held high
    foreach (VEC[i]) begin
      @(negedge clk);
      lowload_n  = VEC[i][8];
      deep_sleep = VEC[i][7];
      strap_off  = VEC[i][6:4];
      fire();
      chk($sformatf("R2/R3/R4/R8/R10 row %0d ph_clk", i), 32'(ph_clk), 32'(VEC[i][3:1]));
      chk($sformatf("R11 row %0d fb_sw", i), 32'(fb_sw), 32'(VEC[i][0]));
      chk($sformatf("R5 row %0d pwm set", i), 32'(ph_pwm), 32'(VEC[i][3:1]));
      @(negedge clk);
      chk($sformatf("R6 row %0d one-cycle pwm", i), 32'(ph_pwm), 0);
      chk($sformatf("R12 row %0d clk width", i), 32'(ph_clk), 0);
    end

    // R5: pwm held until comparator
    lowload_n = 1'b1; deep_sleep = 1'b0; strap_off = '0; ph_off_cmp = '0;
    do_reset();
    fire();
    chk("R5 pwm rises", 32'(ph_pwm), 32'h1);
    repeat (3) @(negedge clk);
    chk("R5 pwm holds", 32'(ph_pwm), 32'h1);
    ph_off_cmp = 3'b001;
    @(negedge clk);
    chk("R5 pwm falls after cmp", 32'(ph_pwm), 32'h0);

    // R6: comparator already high at clock of phase 2
    ph_off_cmp = 3'b010;
    fire();
    chk("R6 min pulse high", 32'(ph_pwm), 32'h2);
    @(negedge clk);
    chk("R6 min pulse ends", 32'(ph_pwm), 32'h0);

    // R7 R9: phase 3 high, shed it between pulses
    ph_off_cmp = 3'b011;
    fire();
    chk("R7 phase 3 set", 32'(ph_pwm), 32'h4);
    lowload_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 pwm untouched before pulse", 32'(ph_pwm), 32'h4);
    chk("R9 fb_sw untouched before pulse", 32'(fb_sw), 32'h0);
    fire();
    chk("R7 shed phase forced low", 32'(ph_pwm[2]), 32'h0);
    chk("R7 clock to phase 1", 32'(ph_clk), 32'h1);
    chk("R11 dual mode", 32'(fb_sw), 32'h1);

    // R8: strap bit 0 has no effect
    strap_off = 3'b001; lowload_n = 1'b1;
    do_reset();
    fire();
    chk("R8 strap bit0 ignored", 32'(ph_clk), 32'h1);
    fire();
    chk("R8 strap bit0 ignored next", 32'(ph_clk), 32'h2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule